// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software sets pin directions with two write-one strobes. One strobe turns pins into outputs and the other turns pins into inputs, so a single write never disturbs pins it does not name. The output latch is split into a low half and a high half of 16 pins each. Each half is updated by a single write that carries its own per-bit mask, so chosen pins change without a read-modify-write sequence.

The pad side has three per-pin buses: output data, output enable and raw pin level. The raw level passes through a two-stage synchroniser before software can read it. The output latch always drives the output-data bus, whatever the pin's direction. A value can therefore be preloaded while a pin is still an input, and it appears at the pad as soon as the pin is switched to output.

The bus has a write strobe, a word address, write data and read data. Reads are combinational from the address and have no side effects.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to offset 0x00 sets the direction bit to output (1) for every pin whose write-data bit is 1. Pins whose bit is 0 keep their direction.
- R2: A write to offset 0x04 clears the direction bit to input (0) for every pin whose write-data bit is 1. Pins whose bit is 0 keep their direction.
- R3: Reads of offset 0x00 and offset 0x04 both return the 32-bit direction mask, with 1 meaning output. `pin_oe` equals that mask at all times.
- R4: A write to offset 0x08 updates pins 0..15. Write-data bits 31:16 are a mask and bits 15:0 are data. Only the pins whose mask bit is 1 take the data bit, and all other pins keep their latched value. A read of 0x08 returns the low latch in bits 15:0 and zeros in bits 31:16.
- R5: A write to offset 0x0C updates pins 16..31 in the same way. Mask bit 16+k and data bit k apply to pin 16+k, and a read of 0x0C returns the high latch in bits 15:0 with zeros above.
- R6: `pin_out` always reflects the output latch, whatever the direction. A value written while a pin is an input is driven on the cycle after that pin is made an output.
- R7: A read of offset 0x10 returns the pin levels as they were two clock edges earlier, through a two-flop synchroniser.
- R8: While reset is asserted (active-low `rst_n`), all pins are inputs and all latch bits are 0.
- R9: Writes to any offset other than 0x00, 0x04, 0x08 and 0x0C change nothing, including writes to 0x10. Reads from offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Per-pin output data |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |

## Verification
The properties assume that `addr` and `wdata` are stable and known at every rising edge while `wr_en` is high. They also assume that `pin_in` is sampled only at clock edges, so the synchroniser's two-edge delay can be stated exactly. The stimulus changes every bus and pin input only on the falling clock edge, which keeps all of these assumptions true. The read-delay property is enabled only once two edges have passed since reset, because the synchroniser does not yet hold real pin history before then.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0]   rdata,
  input  logic [2*HALF_W-1:0]   pin_in,
  output logic [2*HALF_W-1:0]   pin_out,
  output logic [2*HALF_W-1:0]   pin_oe
);
  localparam int NPIN = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] OFS_MK_OUT = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_MK_IN  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_LAT_LO = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_LAT_HI = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = ADDR_W'('h10);

  logic [NPIN-1:0]   dir_q;
  logic [NPIN-1:0]   meta_q, sync_q;
  logic [HALF_W-1:0] lat_q [2];

  wire [HALF_W-1:0] wr_mask = wdata[NPIN-1:HALF_W];
  wire [HALF_W-1:0] wr_bits = wdata[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dir_q <= '0;
    else if (wr_en && addr == OFS_MK_OUT)
      dir_q <= dir_q | wdata;
    else if (wr_en && addr == OFS_MK_IN)
      dir_q <= dir_q & ~wdata;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] OFS_HALF = (h == 0) ? OFS_LAT_LO : OFS_LAT_HI;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lat_q[h] <= '0;
      else if (wr_en && addr == OFS_HALF)
        lat_q[h] <= (lat_q[h] & ~wr_mask) | (wr_bits & wr_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    case (addr)
      OFS_MK_OUT, OFS_MK_IN: rdata = dir_q;
      OFS_LAT_LO:            rdata = {{HALF_W{1'b0}}, lat_q[0]};
      OFS_LAT_HI:            rdata = {{HALF_W{1'b0}}, lat_q[1]};
      OFS_LEVEL:             rdata = sync_q;
      default:               rdata = '0;
    endcase
  end

  assign pin_out = {lat_q[1], lat_q[0]};
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [2*HALF_W-1:0] wdata,
  input logic [2*HALF_W-1:0] rdata,
  input logic [2*HALF_W-1:0] pin_in,
  input logic [2*HALF_W-1:0] pin_out,
  input logic [2*HALF_W-1:0] pin_oe
);
  localparam int NPIN = 2 * HALF_W;
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  wire wr_out = wr_en && addr == ADDR_W'('h00);
  wire wr_inp = wr_en && addr == ADDR_W'('h04);
  wire wr_lo  = wr_en && addr == ADDR_W'('h08);
  wire wr_hi  = wr_en && addr == ADDR_W'('h0C);
  wire known  = addr == ADDR_W'('h00) || addr == ADDR_W'('h04) || addr == ADDR_W'('h08)
             || addr == ADDR_W'('h0C) || addr == ADDR_W'('h10);

  a_r1_set_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> pin_oe == ($past(pin_oe) | $past(wdata)));
  a_r2_set_in: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inp |=> pin_oe == ($past(pin_oe) & ~$past(wdata)));
  a_r3_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'('h00) || addr == ADDR_W'('h04)) |-> rdata == pin_oe);
  a_r4_low_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> pin_out[HALF_W-1:0] ==
      (($past(pin_out[HALF_W-1:0]) & ~$past(wdata[NPIN-1:HALF_W]))
       | ($past(wdata[HALF_W-1:0]) & $past(wdata[NPIN-1:HALF_W])))
      && $stable(pin_out[NPIN-1:HALF_W]));
  a_r5_high_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> pin_out[NPIN-1:HALF_W] ==
      (($past(pin_out[NPIN-1:HALF_W]) & ~$past(wdata[NPIN-1:HALF_W]))
       | ($past(wdata[HALF_W-1:0]) & $past(wdata[NPIN-1:HALF_W])))
      && $stable(pin_out[HALF_W-1:0]));
  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'('h10) && since_rst >= 2'd2) |-> rdata == $past(pin_in, 2));
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_out || wr_inp || wr_lo || wr_hi) |=> $stable(pin_oe) && $stable(pin_out));
  a_r9_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> rdata == '0);

  always @(negedge clk)
    if (!rst_n) a_r8_reset_state: assert (pin_oe == '0 && pin_out == '0);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pin_in, pin_out, pin_oe;
  int checks = 0, errors = 0;

  gpio_mask_port uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R8 oe in reset", pin_oe, 32'h0);
    chk("R8 out in reset", pin_out, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(5'h00, v); chk("R8 dir after reset", v, 32'h0);
  endtask

  task automatic t_direction;
    logic [31:0] v;
    wr(5'h00, 32'hF0F0_00FF);
    chk("R1 set out", pin_oe, 32'hF0F0_00FF);
    wr(5'h00, 32'h0000_0100);
    chk("R1 zeros keep", pin_oe, 32'hF0F0_01FF);
    wr(5'h04, 32'h8000_0003);
    chk("R2 set in", pin_oe, 32'h70F0_01FC);
    rd(5'h00, v); chk("R3 read 0x00", v, 32'h70F0_01FC);
    rd(5'h04, v); chk("R3 read 0x04", v, 32'h70F0_01FC);
    wr(5'h04, 32'hFFFF_FFFF);
    chk("R2 all in", pin_oe, 32'h0);
  endtask

  task automatic t_latch;
    logic [31:0] v;
    wr(5'h08, 32'hFFFF_A5A5);
    chk("R4 full low", pin_out, 32'h0000_A5A5);
    wr(5'h08, 32'h00F0_FFFF);
    chk("R4 masked low", pin_out, 32'h0000_A5F5);
    rd(5'h08, v); chk("R4 read low", v, 32'h0000_A5F5);
    wr(5'h0C, 32'h8001_FFFE);
    chk("R5 masked high", pin_out, 32'h8000_A5F5);
    wr(5'h0C, 32'h0000_FFFF);
    chk("R5 empty mask", pin_out, 32'h8000_A5F5);
    rd(5'h0C, v); chk("R5 read high", v, 32'h0000_8000);
  endtask

  task automatic t_preload;
    wr(5'h0C, 32'h0004_0004);
    chk("R6 preload out bus", pin_out[18], 1'b1);
    chk("R6 still input", pin_oe[18], 1'b0);
    @(negedge clk); wr_en = 1'b1; addr = 5'h00; wdata = 32'h0004_0000;
    @(posedge clk); #0.5;
    chk("R6 drive next cycle", {31'b0, pin_oe[18] & pin_out[18]}, 32'h1);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_sync;
    logic [31:0] v;
    @(negedge clk); pin_in = 32'h1234_5678;
    @(negedge clk); @(negedge clk);
    rd(5'h10, v); chk("R7 after two", v, 32'h1234_5678);
    addr = 5'h10;
    @(negedge clk); pin_in = 32'hCAFE_0001;
    @(negedge clk); #0.5; chk("R7 one edge old", rdata, 32'h1234_5678);
    @(negedge clk); #0.5; chk("R7 two edges new", rdata, 32'hCAFE_0001);
  endtask

  task automatic t_undef;
    logic [31:0] v, oe0, out0;
    oe0 = pin_oe; out0 = pin_out;
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    chk("R9 oe unchanged", pin_oe, oe0);
    chk("R9 out unchanged", pin_out, out0);
    rd(5'h14, v); chk("R9 read 0x14", v, 32'h0);
    rd(5'h1C, v); chk("R9 read 0x1C", v, 32'h0);
  endtask

  initial begin
    pin_in = '0;
    #1;
    t_reset();
    t_direction();
    t_latch();
    t_preload();
    t_sync();
    t_undef();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule